// File: doc/BRIEF.md
# Four-Mode Test Register Chain

This block is a bank of flip-flops placed in front of a combinational circuit under test. A two-bit mode code selects one of four behaviours for the whole chain. In functional capture, every cell takes its parallel input. In scan, the cells form a shift chain fed from an external serial input. In pattern generation, the chain runs as an internal-feedback linear feedback shift register and produces a pseudo-random sequence. In signature compression, the same feedback register also XORs the parallel inputs into each cell, so it folds a stream of response words into one signature.

A test controller, which is outside this block, scans in a nonzero seed, runs the generator for as many cycles as the test needs, and then switches to compression to collect the responses. It reads the result through the parallel output or shifts it out through the serial output. The feedback polynomial is a fixed parameter. Its default is the primitive polynomial x^8+x^6+x^5+x^4+1 over an 8-cell chain.

The block has no streaming data path. The mode, serial and parallel pins are plain signals sampled on every clock edge, so the block needs no valid/ready handshake and applies no back-pressure.

Top module: `mtr_chain`

## Requirements
- R1: When `rst` is high at a rising clock edge, every cell becomes 0 whatever the mode.
- R2: With mode 2'b00 (capture), `par_out` after the edge equals `par_in` before it.
- R3: With mode 2'b01 (scan), the next `par_out` is `{par_out[W-2:0], scan_in}`: data moves toward bit W-1, and `par_in` has no effect.
- R4: `scan_out` equals `par_out[W-1]` in all four modes.
- R5: With mode 2'b10 (generate), the next state is `(par_out << 1) ^ (par_out[W-1] ? TAPS : 0)`, truncated to W bits, and `par_in` has no effect.
- R6: With mode 2'b11 (compress), the next state is the R5 value XORed with `par_in`.
- R7: With the default TAPS = 8'h71, generation from a nonzero seed first returns to that seed after exactly 255 steps and never reaches zero on the way.
- R8: Generation from the all-zero state stays at zero.
- R9: Two compression runs over input streams that differ in exactly one bit end with different signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all cells update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of every cell |
| mode | input | 2 | 00 capture, 01 scan, 10 generate, 11 compress |
| par_in | input | W | Parallel data, one bit per cell |
| scan_in | input | 1 | Serial input to cell 0 in scan mode |
| par_out | output | W | Current contents of the cells |
| scan_out | output | 1 | Last cell of the chain |

## Verification
A fixed vector sequence runs capture, scan and generation with `par_in` held at all-ones, so any leak of the parallel input into the scan or generate path shows up in the result. Generation steps with the top cell set and with it clear, which separates the feedback term from a plain shift. Compression vectors use inputs that hit the top cell and the low nibble, which tells the XOR of the parallel data apart from the feedback taps. A full-period walk from a scanned-in seed confirms that the default polynomial is maximal-length. A pair of compression runs that differ in a single flipped bit shows that single errors are not masked.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  typedef enum logic [1:0] {
    MTR_CAPTURE  = 2'b00,
    MTR_SCAN     = 2'b01,
    MTR_GENERATE = 2'b10,
    MTR_COMPRESS = 2'b11
  } mtr_mode_e;
endpackage

// File: rtl/mtr_taps.sv
// Internal-form feedback: the last cell's bit is spread onto every tapped stage.
module mtr_taps #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'h71
) (
  input  logic         fb_bit,
  output logic [W-1:0] fb_term
);
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign fb_term[i] = fb_bit;
    end else begin : g_off
      assign fb_term[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mtr_cell.sv
module mtr_cell
  import mtr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       d,
  input  logic       si,
  input  logic       fb_term,
  output logic       q
);
  mtr_mode_e md;
  logic      nxt;

  assign md = mtr_mode_e'(mode);

  always_comb begin
    unique case (md)
      MTR_CAPTURE:  nxt = d;
      MTR_SCAN:     nxt = si;
      MTR_GENERATE: nxt = si ^ fb_term;
      MTR_COMPRESS: nxt = si ^ fb_term ^ d;
      default:      nxt = d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  AST_CELL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (md == MTR_CAPTURE) |=> (q == $past(d))); // R2
endmodule

// File: rtl/mtr_chain.sv
module mtr_chain
  import mtr_pkg::*;
#(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] TAPS = 8'h71
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         scan_in,
  output logic [W-1:0] par_out,
  output logic         scan_out
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] cell_q;
  logic [W-1:0] cell_si;
  logic [W-1:0] fb_term;
  logic         head_si;

  assign head_si = (mtr_mode_e'(mode) == MTR_SCAN) ? scan_in : 1'b0;

  mtr_taps #(.W(W), .TAPS(TAPS)) u_taps (
    .fb_bit  (cell_q[LAST]),
    .fb_term (fb_term)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign cell_si[i] = head_si;
    end else begin : g_body
      assign cell_si[i] = cell_q[i-1];
    end
    mtr_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .d       (par_in[i]),
      .si      (cell_si[i]),
      .fb_term (fb_term[i]),
      .q       (cell_q[i])
    );
  end

  assign par_out  = cell_q;
  assign scan_out = cell_q[LAST];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (par_out == '0)); // R1
  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (par_out == {$past(par_out[W-2:0]), $past(scan_in)})); // R3
  AST_GEN_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b10) && (par_out == '0)) |=> (par_out == '0)); // R8
  AST_GEN_NONZERO_KEPT: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b10) && (par_out != '0)) |=> (par_out != '0)); // R7
  AST_GEN_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b10) && !scan_out) |=> (par_out == {$past(par_out[W-2:0]), 1'b0})); // R5
endmodule

// File: tb/mtr_chain_tb.sv
module mtr_chain_tb_top;
  localparam int unsigned W   = 8;
  localparam time         CLK = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic [W-1:0] par_in;
  logic         scan_in;
  logic [W-1:0] par_out;
  logic         scan_out;

  int checks   = 0;
  int failures = 0;

  always #(CLK/2) clk = ~clk;

  mtr_chain #(.W(W), .TAPS(8'h71)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
    .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  // {mode, par_in, scan_in, expected par_out}, applied in order after reset
  localparam logic [18:0] VEC [12] = '{
    {2'b00, 8'hA5, 1'b0, 8'hA5},  // R2
    {2'b00, 8'h3C, 1'b1, 8'h3C},  // R2
    {2'b01, 8'hFF, 1'b1, 8'h79},  // R3 par_in ignored
    {2'b01, 8'h00, 1'b0, 8'hF2},  // R3
    {2'b10, 8'hFF, 1'b1, 8'h95},  // R5 top set, par_in ignored
    {2'b10, 8'hFF, 1'b0, 8'h5B},  // R5
    {2'b10, 8'h00, 1'b0, 8'hB6},  // R5 top clear
    {2'b11, 8'h0F, 1'b0, 8'h12},  // R6
    {2'b11, 8'h80, 1'b0, 8'hA4},  // R6
    {2'b11, 8'h00, 1'b0, 8'h39},  // R6
    {2'b00, 8'h00, 1'b0, 8'h00},  // R2
    {2'b10, 8'h5A, 1'b1, 8'h00}   // R8
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic s);
    @(negedge clk);
    mode = m; par_in = d; scan_in = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mode = 2'b00; par_in = 8'hFF; scan_in = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [W-1:0] stream_word(input int k);
    return W'((k * 13 + 7) & 8'hFF);
  endfunction

  logic [W-1:0] sig_a;
  logic [W-1:0] sig_b;

  initial begin
    #(CLK * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'b00; par_in = '0; scan_in = 1'b0;
    do_reset();
    check("R1 reset state", par_out, 8'h00);
    check("R4 scan_out after reset", {7'd0, scan_out}, 8'h00);

    for (int v = 0; v < 12; v++) begin
      step(VEC[v][18:17], VEC[v][16:9], VEC[v][8]);
      check($sformatf("R2/R3/R5/R6/R8 vector %0d", v), par_out, VEC[v][7:0]);
      check($sformatf("R4 vector %0d", v), {7'd0, scan_out}, {7'd0, VEC[v][7]});
    end

    // R1: reset wins over capture of all-ones
    step(2'b00, 8'hFF, 1'b1);
    @(negedge clk);
    rst = 1'b1; mode = 2'b11; par_in = 8'hFF;
    @(posedge clk);
    #1;
    check("R1 reset overrides mode", par_out, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // R7: scan in seed 8'h01, then count the generator period
    for (int b = W - 1; b >= 0; b--) step(2'b01, 8'hFF, (b == 0));
    check("R3 seed scanned", par_out, 8'h01);
    begin
      int period = 0;
      bit hit_zero = 0;
      for (int n = 1; n <= 300; n++) begin
        step(2'b10, 8'hA5, 1'b0);
        if (par_out == 8'h00) hit_zero = 1;
        if (par_out == 8'h01) begin
          period = n;
          break;
        end
      end
      check("R7 period", W'(period), 8'd255);
      check("R7 no zero state", {7'd0, hit_zero}, 8'h00);
    end

    // R9: two compression runs, second with one flipped bit
    do_reset();
    for (int k = 0; k < 16; k++) step(2'b11, stream_word(k), 1'b0);
    sig_a = par_out;
    do_reset();
    for (int k = 0; k < 16; k++)
      step(2'b11, stream_word(k) ^ ((k == 5) ? 8'h04 : 8'h00), 1'b0);
    sig_b = par_out;
    checks++;
    if (sig_a == sig_b) begin
      failures++;
      $display("FAIL R9 actual=%h expected!=%h", sig_b, sig_a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule